// File: doc/BRIEF.md
# Power-down and wake-up sequencer

This block sequences the low-power mode of a small microcontroller core. A one-cycle strobe from instruction decode asks for power-down. The request is honoured only while a configuration enable bit is set. That bit is forced to 1 by reset and can be rewritten by a configuration write. While powered down, the block removes the enable of the internal clock tree and holds the bus-control outputs inactive. It also freezes the watchdog, and it pulses an abort to the analog-to-digital converter once, on entry.

The block leaves power-down on a chip reset, or on a high level on the wake source. The wake source is either a dedicated external interrupt pin or bit 7 of port 0, as chosen by a select input. The wake level is synchronised and must then stay high for a programmable number of reference cycles before the clocks restart. If the level drops inside that window, the block falls back to power-down and the count starts again.

When the clocks restart, the block pulses the set input of the wake interrupt's pending flag. The interrupt mask does not affect this. In the same cycle it reports whether the core must vector to the service routine (interrupt unmasked) or resume at the next instruction (masked). The oscillator, the delay capacitor and the datapath stay outside; the block drives only enables and flags.

Top module: `pd_wake_ctrl`

## Requirements
- R1: After reset, clk_en_o is 1 and bus_idle_force_o, wdt_freeze_o, adc_abort_o, int7_pend_set_o and vector_now_o are all 0. The power-down enable bit is 1.
- R2: A pd_req_i strobe in the run state, with the enable bit at 1, makes the outputs change in the next cycle: clk_en_o goes to 0, and bus_idle_force_o and wdt_freeze_o go to 1. They hold those values until the clocks restart.
- R3: cfg_wr_i loads cfg_pd_en_i into the enable bit. A pd_req_i strobe has no effect while the bit is 0. If a write and a request fall in the same cycle, the bit's value before the write decides whether power-down is entered.
- R4: adc_abort_o is high for exactly one cycle: the first cycle of power-down.
- R5: The wake level is ext_int_i when wake_sel_i is 0 and port0_b7_i when wake_sel_i is 1. The pin that is not selected has no effect.
- R6: The wake level is passed through SYNC_STAGES flops, and the stabilisation count then needs STAB_CYCLES cycles of it held high. The wake level is raised just after a clock edge. clk_en_o is then 0 for exactly SYNC_STAGES+1+STAB_CYCLES further cycles and is 1 in the cycle after those.
- R7: If the synchronised wake level falls during stabilisation, the block returns to power-down and the count restarts from zero.
- R8: In the cycle the clocks restart, int7_pend_set_o is high for one cycle, whatever the mask. In that cycle vector_now_o equals int7_unmask_i. At all other times vector_now_o is 0.
- R9: An asserted rst_ni during power-down or stabilisation returns the block to the run state at once and reloads the enable bit to 1.
- R10: pd_req_i strobes outside the run state have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous active-low chip reset |
| pd_req_i | input | 1 | Power-down strobe from instruction decode |
| cfg_wr_i | input | 1 | Write strobe for the power-down enable bit |
| cfg_pd_en_i | input | 1 | Value written to the enable bit |
| wake_sel_i | input | 1 | Wake source: 0 external pin, 1 port 0 bit 7 |
| ext_int_i | input | 1 | Dedicated external interrupt pin |
| port0_b7_i | input | 1 | Port 0 bit 7 pin |
| int7_unmask_i | input | 1 | 1 when the wake interrupt is unmasked |
| clk_en_o | output | 1 | Internal clock tree enable |
| bus_idle_force_o | output | 1 | Forces bus-control outputs inactive |
| adc_abort_o | output | 1 | One-cycle converter abort at entry |
| wdt_freeze_o | output | 1 | Stops the watchdog counter |
| int7_pend_set_o | output | 1 | One-cycle set of the wake interrupt pending flag |
| vector_now_o | output | 1 | Vector to the service routine on restart |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a power-down request and a configuration write that clears the enable bit. The bench drives both in one cycle and expects entry, because the old bit governs. It then expects a later request to be ignored. The second pair is a reset and an ongoing stabilisation count. The bench asserts reset a few cycles into the count and expects the run outputs at once. It then expects a fresh request to enter power-down, which shows that the enable bit was reloaded.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    PD_RUN    = 2'd0,
    PD_DOWN   = 2'd1,
    PD_STAB   = 2'd2,
    PD_RESUME = 2'd3
  } pd_state_e;
endpackage

// File: rtl/pd_wake_sync.sv
module pd_wake_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_port_i,
  input  logic ext_pin_i,
  input  logic port_pin_i,
  output logic wake_o
);
  logic raw;
  logic [STAGES-1:0] chain_q;

  assign raw = sel_port_i ? port_pin_i : ext_pin_i;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= raw;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], raw};
    end
  endgenerate

  assign wake_o = chain_q[STAGES-1];
endmodule

// File: rtl/pd_stab_timer.sv
module pd_stab_timer #(
  parameter int unsigned CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // any break in run clears the count
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
  import pd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pd_req_i,
  input  logic      cfg_wr_i,
  input  logic      cfg_pd_en_i,
  input  logic      wake_i,
  input  logic      stab_done_i,
  output pd_state_e state_o,
  output logic      abort_o
);
  pd_state_e state_q, state_d;
  logic      pd_en_q;
  logic      enter;

  assign enter = (state_q == PD_RUN) && pd_req_i && pd_en_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PD_RUN:    if (enter) state_d = PD_DOWN;
      PD_DOWN:   if (wake_i) state_d = PD_STAB;
      PD_STAB:   if (!wake_i) state_d = PD_DOWN;
                 else if (stab_done_i) state_d = PD_RESUME;
      PD_RESUME: state_d = PD_RUN;
      default:   state_d = PD_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= PD_RUN;
      pd_en_q <= 1'b1;
      abort_o <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_o <= enter;
      if (cfg_wr_i) pd_en_q <= cfg_pd_en_i;
    end

  assign state_o = state_q;
endmodule

// File: rtl/pd_wake_ctrl.sv
module pd_wake_ctrl
  import pd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STAB_CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_req_i,
  input  logic cfg_wr_i,
  input  logic cfg_pd_en_i,
  input  logic wake_sel_i,
  input  logic ext_int_i,
  input  logic port0_b7_i,
  input  logic int7_unmask_i,
  output logic clk_en_o,
  output logic bus_idle_force_o,
  output logic adc_abort_o,
  output logic wdt_freeze_o,
  output logic int7_pend_set_o,
  output logic vector_now_o
);
  pd_state_e state;
  logic      wake_s;
  logic      stab_done;
  logic      asleep;

  pd_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_port_i (wake_sel_i),
    .ext_pin_i  (ext_int_i),
    .port_pin_i (port0_b7_i),
    .wake_o     (wake_s)
  );

  pd_stab_timer #(.CYCLES(STAB_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  ((state == PD_STAB) && wake_s),
    .done_o (stab_done)
  );

  pd_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pd_req_i    (pd_req_i),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_pd_en_i (cfg_pd_en_i),
    .wake_i      (wake_s),
    .stab_done_i (stab_done),
    .state_o     (state),
    .abort_o     (adc_abort_o)
  );

  assign asleep           = (state == PD_DOWN) || (state == PD_STAB);
  assign clk_en_o         = !asleep;
  assign bus_idle_force_o = asleep;
  assign wdt_freeze_o     = asleep;
  assign int7_pend_set_o  = (state == PD_RESUME);
  assign vector_now_o     = (state == PD_RESUME) && int7_unmask_i;
endmodule

// File: rtl/pd_wake_ctrl_chk.sv
module pd_wake_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clk_en_o,
  input logic bus_idle_force_o,
  input logic adc_abort_o,
  input logic wdt_freeze_o,
  input logic int7_pend_set_o,
  input logic vector_now_o
);
  a_r2_bus_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_idle_force_o |-> !clk_en_o);
  a_r2_wdt_with_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_freeze_o == bus_idle_force_o);
  a_r4_abort_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_abort_o |=> !adc_abort_o);
  a_r4_abort_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_abort_o |-> (!clk_en_o && $past(clk_en_o)));
  a_r8_pend_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int7_pend_set_o |-> (clk_en_o && $past(bus_idle_force_o)));
  a_r8_pend_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int7_pend_set_o |=> (!int7_pend_set_o && clk_en_o));
  a_r8_vector_with_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_now_o |-> int7_pend_set_o);
  a_r6_restart_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && $past(!clk_en_o)) |-> int7_pend_set_o);
endmodule

bind pd_wake_ctrl pd_wake_ctrl_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .clk_en_o         (clk_en_o),
  .bus_idle_force_o (bus_idle_force_o),
  .adc_abort_o      (adc_abort_o),
  .wdt_freeze_o     (wdt_freeze_o),
  .int7_pend_set_o  (int7_pend_set_o),
  .vector_now_o     (vector_now_o)
);

// File: tb/pd_wake_ctrl_test.sv
module pd_wake_ctrl_test;
  localparam int PERIOD = 10;
  localparam int SYNC   = 2;
  localparam int STAB   = 8;
  localparam int WAKE_LAT = SYNC + 1 + STAB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 0, cfg_wr = 0, cfg_val = 0, sel = 0, ext = 0, p07 = 0, unmask = 0;
  logic clk_en, bus_f, abort, wdt_f, pend, vec;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  pd_wake_ctrl #(.SYNC_STAGES(SYNC), .STAB_CYCLES(STAB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pd_req_i(pd_req), .cfg_wr_i(cfg_wr),
    .cfg_pd_en_i(cfg_val), .wake_sel_i(sel), .ext_int_i(ext),
    .port0_b7_i(p07), .int7_unmask_i(unmask), .clk_en_o(clk_en),
    .bus_idle_force_o(bus_f), .adc_abort_o(abort), .wdt_freeze_o(wdt_f),
    .int7_pend_set_o(pend), .vector_now_o(vec)
  );

  // behavioural reference: 0 run, 1 down, 2 settle, 3 restart
  int m_st, m_cnt;
  bit m_en, m_abort;
  bit syncq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_en = 1; m_abort = 0;
      syncq.delete();
      for (int i = 0; i < SYNC; i++) syncq.push_back(1'b0);
    end else begin
      bit ws;
      ws = syncq.pop_front();
      syncq.push_back(sel ? p07 : ext);
      m_abort = (m_st == 0) && pd_req && m_en;
      case (m_st)
        0: if (pd_req && m_en) m_st = 1;
        1: if (ws) begin m_st = 2; m_cnt = 0; end
        2: if (!ws) m_st = 1;
           else if (m_cnt == STAB - 1) m_st = 3;
           else m_cnt++;
        default: m_st = 0;
      endcase
      if (cfg_wr) m_en = cfg_val;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 clk_en", clk_en, (m_st == 0) || (m_st == 3));
    chk("R2 bus_idle_force", bus_f, (m_st == 1) || (m_st == 2));
    chk("R2 wdt_freeze", wdt_f, (m_st == 1) || (m_st == 2));
    chk("R4 adc_abort", abort, m_abort);
    chk("R8 pend_set", pend, m_st == 3);
    chk("R8 vector_now", vec, (m_st == 3) && unmask);
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic enter_pd();
    tick(); pd_req = 1; tick(); pd_req = 0;
  endtask

  // counts low-clock cycles after the wake level is raised, ends on restart
  task automatic wait_wake(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (clk_en) break;
      n++;
      if (n > 4 * WAKE_LAT) break;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) tick();
    @(negedge clk);
    chk("R1 clk_en", clk_en, 1'b1);
    chk("R1 bus_idle_force", bus_f, 1'b0);
    chk("R1 abort", abort, 1'b0);
    chk("R1 pend", pend, 1'b0);
    chk("R1 vector", vec, 1'b0);
    chk("R1 wdt", wdt_f, 1'b0);
    tick(); rst_n = 1;

    // unmasked wake via the dedicated pin
    unmask = 1; sel = 0;
    enter_pd();
    @(negedge clk);
    chk("R2 gated", clk_en, 1'b0);
    chk("R4 pulse", abort, 1'b1);
    tick(); @(negedge clk);
    chk("R4 pulse end", abort, 1'b0);
    enter_pd();
    @(negedge clk);
    chk("R10 req in pd", abort, 1'b0);
    chk("R10 still down", clk_en, 1'b0);
    tick(); ext = 1;
    wait_wake(n);
    chk("R6 latency", n == WAKE_LAT, 1'b1);
    chk("R8 pend", pend, 1'b1);
    chk("R8 vector", vec, 1'b1);
    tick(); ext = 0;
    @(negedge clk);
    chk("R8 pend once", pend, 1'b0);

    // masked wake via port 0 bit 7; dedicated pin ignored
    unmask = 0; sel = 1;
    enter_pd();
    tick(); ext = 1;
    repeat (WAKE_LAT + 5) tick();
    @(negedge clk);
    chk("R5 unselected pin", clk_en, 1'b0);
    tick(); ext = 0; p07 = 1;
    wait_wake(n);
    chk("R5 port wake", n == WAKE_LAT, 1'b1);
    chk("R8 masked pend", pend, 1'b1);
    chk("R8 masked vector", vec, 1'b0);
    tick(); p07 = 0;

    // glitch inside stabilisation restarts the count
    sel = 0; unmask = 1;
    enter_pd();
    tick(); ext = 1;
    repeat (SYNC + 1 + STAB / 2) tick();
    ext = 0;
    repeat (SYNC + 3) tick();
    @(negedge clk);
    chk("R7 back down", clk_en, 1'b0);
    tick(); ext = 1;
    wait_wake(n);
    chk("R7 full recount", n == WAKE_LAT, 1'b1);
    tick(); ext = 0;

    // enable cleared: requests ignored
    tick(); cfg_wr = 1; cfg_val = 0; tick(); cfg_wr = 0;
    enter_pd();
    @(negedge clk);
    chk("R3 disabled clk", clk_en, 1'b1);
    chk("R3 disabled abort", abort, 1'b0);
    tick(); cfg_wr = 1; cfg_val = 1; tick(); cfg_wr = 0;

    // same-cycle request and clear: old bit rules
    tick(); pd_req = 1; cfg_wr = 1; cfg_val = 0; tick(); pd_req = 0; cfg_wr = 0;
    @(negedge clk);
    chk("R3 old bit entry", clk_en, 1'b0);

    // reset during stabilisation
    tick(); ext = 1;
    repeat (SYNC + 3) tick();
    rst_n = 0;
    #1;
    chk("R9 reset clk", clk_en, 1'b1);
    chk("R9 reset bus", bus_f, 1'b0);
    tick(); rst_n = 1; ext = 0;
    enter_pd();
    @(negedge clk);
    chk("R9 enable reloaded", clk_en, 1'b0);
    tick(); ext = 1;
    wait_wake(n);
    chk("R9 wake after reload", n == WAKE_LAT, 1'b1);
    tick(); ext = 0;
    repeat (3) tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule